// File: doc/BRIEF.md
# PCM Ping-Pong Playback Streamer

This block plays audio from a circular buffer in memory. Software sets a start address, a buffer length and a sample format, then turns playback on. The block reads the buffer one 32-bit word at a time. It unpacks each word into stereo 16-bit frames and hands the frames to a DAC stream through a valid/ready handshake.

The buffer is treated as two equal halves. When the read pointer crosses into the second half, the block raises a half-done flag. When it wraps back to the start, it raises a wrap-done flag. Software refills one half while the other one plays. The block also reports which reference clock and which total division ratio the codec bit clock should use.

Top module: `pcm_dma_player`

## Requirements
- R1: After reset, the mode, flag and interrupt-mask registers read 0, the position register reads 0, `irq` is low and `memReq` is low.
- R2: Register writes place a byte address in the start register: offset 0x28 loads bits 15:0 and offset 0x40 loads bits 31:16, each from write data bits 15:0. `memReq` is asserted only while mode bit 7 (run) is 1. `memAddr` is always the start address plus the current byte offset into the buffer, and this offset grows by 4 per word.
- R3: With mode bit 0 set (16-bit samples) and mode bit 14 clear (stereo), each word gives one frame: left is bits 15:0 and right is bits 31:16.
- R4: With mode bits 0 and 14 both set (16-bit mono), each word gives two frames, bits 15:0 first and then bits 31:16. Each sample is copied to both channels.
- R5: With mode bits 0 and 14 both clear (8-bit stereo), each word gives two frames. The bytes are taken from bit 0 upward in the order left, right, left, right, and each byte is multiplied by 256.
- R6: With mode bit 0 clear and bit 14 set (8-bit mono), each word gives four frames, lowest byte first. Each byte is multiplied by 256 and copied to both channels.
- R7: A write of v to offset 0x2C sets the buffer length to (v+1)*4 bytes and the half length to (v+1)*2 bytes. When a word finishes and the next offset reaches the buffer length, flag bit 7 is set, the offset returns to 0 and the position becomes 0. When a word finishes and the offset crosses the half length without wrapping, flag bit 6 is set and the position becomes the half length. If both conditions happen on the same word, only bit 7 is set. Offset 0x38 reads back the position divided by 4.
- R8: `irq` is high exactly when the flags at offset 0x20 ANDed with the mask at offset 0x24 (bits 7:6) are non-zero. A mask write takes effect one cycle later.
- R9: Writing 1s to offset 0x20 clears those flag bits. If a flag is set by the pointer in the same cycle as it is cleared, the set wins.
- R10: Writing the mode register at offset 0x00 with bit 7 going from 0 to 1 clears the flags and the position, and restarts fetching at the start address.
- R11: `bclkRefSel` equals mode bit 9: 1 selects the 24.576 MHz reference and 0 selects the 11.2896 MHz reference. `bclkDivisor` equals 64*(divider bits 15:8 + 1), where the divider register is at offset 0x18.
- R12: While `sampleValid` is high and `sampleReady` is low, with no register write, the sample outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset for both read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr`, combinational |
| memReq | output | 1 | Memory word read request |
| memAddr | output | 32 | Memory byte address |
| memRdata | input | 32 | Read data, valid the cycle after `memReq` |
| sampleValid | output | 1 | Frame available |
| sampleReady | input | 1 | Sink takes the frame |
| sampleLeft | output | 16 | Left channel sample |
| sampleRight | output | 16 | Right channel sample |
| irq | output | 1 | Interrupt request |
| bclkRefSel | output | 1 | Selected reference clock for the bit clock |
| bclkDivisor | output | 15 | Total division from the reference to the bit clock |

## Verification
The hardest cases to reach from the ports are two pointer events. The first is the half-crossing, and the second is the case where a single word both crosses the half and wraps, which only happens with a one-word buffer. The stimulus reaches them by running an exact number of handshakes against small buffer lengths, then reading the position and the flags. It also sets the threshold to 0 to force the combined event. Pseudo-random ready stalls, plus disable and re-enable in the middle of a buffer, exercise holding and restarting for each of the four sample formats.

// File: rtl/pcm_dma_pkg.sv
package pcm_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_LOAD, ST_EMIT} playState_e;

  typedef struct packed {
    logic fetch;
    logic load;
    logic step;
    logic wordDone;
  } playStrobe_t;

  localparam int BIT_WIDE = 0;
  localparam int BIT_RUN  = 7;
  localparam int BIT_FAST = 9;
  localparam int BIT_MONO = 14;
  localparam int DIV_LSB  = 8;

  localparam logic [7:0] OFS_MODE   = 8'h00;
  localparam logic [7:0] OFS_DIV    = 8'h18;
  localparam logic [7:0] OFS_FLAG   = 8'h20;
  localparam logic [7:0] OFS_MASK   = 8'h24;
  localparam logic [7:0] OFS_BASELO = 8'h28;
  localparam logic [7:0] OFS_THR    = 8'h2C;
  localparam logic [7:0] OFS_POS    = 8'h38;
  localparam logic [7:0] OFS_BASEHI = 8'h40;
endpackage

// File: rtl/pcm_dma_regs.sv
module pcm_dma_regs
  import pcm_dma_pkg::*;
#(
  parameter int THR_W = 16,
  parameter int DIV_W = 8,
  localparam int POS_W = THR_W + 3,
  localparam int BCLK_W = DIV_W + 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              halfEvt,
  input  logic              fullEvt,
  input  logic [POS_W-1:0]  posBytes,
  output logic              playEn,
  output logic              wideSamp,
  output logic              monoSamp,
  output logic              enStart,
  output logic [31:0]       baseAddr,
  output logic [POS_W-1:0]  bufBytes,
  output logic [POS_W-1:0]  blkBytes,
  output logic              irq,
  output logic              bclkRefSel,
  output logic [BCLK_W-1:0] bclkDivisor
);
  logic [31:0] modeQ, divQ, baseQ;
  logic [THR_W-1:0] thrQ;
  logic [1:0] flagQ, maskQ, clrBits;
  logic [THR_W:0] thrPlus;

  assign enStart = regWr && regAddr == OFS_MODE && regWdata[BIT_RUN] && !modeQ[BIT_RUN];
  assign clrBits = (regWr && regAddr == OFS_FLAG) ? regWdata[7:6] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      divQ  <= '0;
      baseQ <= '0;
      thrQ  <= '0;
      flagQ <= '0;
      maskQ <= '0;
    end else begin
      if (enStart) flagQ <= '0;
      else         flagQ <= (flagQ & ~clrBits) | {fullEvt, halfEvt};
      if (regWr) begin
        case (regAddr)
          OFS_MODE:   modeQ <= regWdata;
          OFS_DIV:    divQ <= regWdata;
          OFS_MASK:   maskQ <= regWdata[7:6];
          OFS_BASELO: baseQ[15:0] <= regWdata[15:0];
          OFS_BASEHI: baseQ[31:16] <= regWdata[15:0];
          OFS_THR:    thrQ <= regWdata[THR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign thrPlus     = {1'b0, thrQ} + 1'b1;
  assign bufBytes    = {thrPlus, 2'b00};
  assign blkBytes    = {1'b0, thrPlus, 1'b0};
  assign playEn      = modeQ[BIT_RUN];
  assign wideSamp    = modeQ[BIT_WIDE];
  assign monoSamp    = modeQ[BIT_MONO];
  assign baseAddr    = baseQ;
  assign irq         = |(flagQ & maskQ);
  assign bclkRefSel  = modeQ[BIT_FAST];
  assign bclkDivisor = {({1'b0, divQ[DIV_LSB +: DIV_W]} + 1'b1), 6'b000000};

  always_comb begin
    case (regAddr)
      OFS_MODE: regRdata = modeQ;
      OFS_DIV:  regRdata = divQ;
      OFS_FLAG: regRdata = {24'd0, flagQ, 6'd0};
      OFS_MASK: regRdata = {24'd0, maskQ, 6'd0};
      OFS_POS:  regRdata = 32'(posBytes >> 2);
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/pcm_dma_ctrl.sv
module pcm_dma_ctrl
  import pcm_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        playEn,
  input  logic        sampleReady,
  input  logic        frameLast,
  output playStrobe_t stb,
  output logic        memReq,
  output logic        sampleValid
);
  playState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    stb = '0;
    sampleValid = 1'b0;
    case (stateQ)
      ST_IDLE:  if (playEn) stateD = ST_FETCH;
      ST_FETCH: begin
        stb.fetch = playEn;
        stateD = ST_LOAD;
      end
      ST_LOAD: begin
        stb.load = playEn;
        stateD = ST_EMIT;
      end
      ST_EMIT: begin
        sampleValid = playEn;
        if (sampleReady && playEn) begin
          stb.step = 1'b1;
          if (frameLast) begin
            stb.wordDone = 1'b1;
            stateD = ST_FETCH;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
    if (!playEn) stateD = ST_IDLE;
  end

  assign memReq = stb.fetch;
endmodule

// File: rtl/pcm_dma_datapath.sv
module pcm_dma_datapath
  import pcm_dma_pkg::*;
#(
  parameter int THR_W = 16,
  localparam int POS_W = THR_W + 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  playStrobe_t      stb,
  input  logic             enStart,
  input  logic             wideSamp,
  input  logic             monoSamp,
  input  logic [31:0]      baseAddr,
  input  logic [POS_W-1:0] bufBytes,
  input  logic [POS_W-1:0] blkBytes,
  input  logic [31:0]      memRdata,
  output logic [31:0]      memAddr,
  output logic [15:0]      sampleLeft,
  output logic [15:0]      sampleRight,
  output logic             frameLast,
  output logic             halfEvt,
  output logic             fullEvt,
  output logic [POS_W-1:0] posBytes
);
  logic [31:0] wordQ;
  logic [1:0] subQ, lastIdx;
  logic [POS_W-1:0] rdQ, posQ, nextRd;
  logic [15:0] half16;
  logic [7:0] monoByte, leftByte, rightByte;

  assign nextRd  = rdQ + POS_W'(4);
  assign fullEvt = stb.wordDone && nextRd >= bufBytes;
  assign halfEvt = stb.wordDone && !fullEvt && rdQ < blkBytes && nextRd >= blkBytes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
      subQ  <= '0;
      rdQ   <= '0;
      posQ  <= '0;
    end else if (enStart) begin
      subQ <= '0;
      rdQ  <= '0;
      posQ <= '0;
    end else begin
      if (stb.load) begin
        wordQ <= memRdata;
        subQ  <= '0;
      end else if (stb.step) begin
        subQ <= subQ + 2'd1;
      end
      if (stb.wordDone) begin
        if (fullEvt) begin
          rdQ  <= '0;
          posQ <= '0;
        end else begin
          rdQ <= nextRd;
          if (halfEvt) posQ <= blkBytes;
        end
      end
    end
  end

  always_comb begin
    case ({wideSamp, monoSamp})
      2'b10:   lastIdx = 2'd0;
      2'b11:   lastIdx = 2'd1;
      2'b00:   lastIdx = 2'd1;
      default: lastIdx = 2'd3;
    endcase
  end
  assign frameLast = subQ == lastIdx;

  assign half16    = subQ[0] ? wordQ[31:16] : wordQ[15:0];
  assign monoByte  = wordQ[{subQ, 3'b000} +: 8];
  assign leftByte  = wordQ[{subQ[0], 4'b0000} +: 8];
  assign rightByte = wordQ[{subQ[0], 4'b1000} +: 8];

  always_comb begin
    case ({wideSamp, monoSamp})
      2'b10: begin sampleLeft = wordQ[15:0];       sampleRight = wordQ[31:16]; end
      2'b11: begin sampleLeft = half16;            sampleRight = half16; end
      2'b00: begin sampleLeft = {leftByte, 8'h00}; sampleRight = {rightByte, 8'h00}; end
      default: begin sampleLeft = {monoByte, 8'h00}; sampleRight = {monoByte, 8'h00}; end
    endcase
  end

  assign memAddr  = baseAddr + 32'(rdQ);
  assign posBytes = posQ;
endmodule

// File: rtl/pcm_dma_player.sv
module pcm_dma_player
  import pcm_dma_pkg::*;
#(
  parameter int THR_W = 16,
  parameter int DIV_W = 8,
  localparam int POS_W = THR_W + 3,
  localparam int BCLK_W = DIV_W + 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memReq,
  output logic [31:0]       memAddr,
  input  logic [31:0]       memRdata,
  output logic              sampleValid,
  input  logic              sampleReady,
  output logic [15:0]       sampleLeft,
  output logic [15:0]       sampleRight,
  output logic              irq,
  output logic              bclkRefSel,
  output logic [BCLK_W-1:0] bclkDivisor
);
  playStrobe_t stb;
  logic playEn, wideSamp, monoSamp, enStart, halfEvt, fullEvt, frameLast;
  logic [31:0] baseAddr;
  logic [POS_W-1:0] bufBytes, blkBytes, posBytes;

  pcm_dma_regs #(.THR_W(THR_W), .DIV_W(DIV_W)) uRegs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .halfEvt(halfEvt), .fullEvt(fullEvt), .posBytes(posBytes),
    .playEn(playEn), .wideSamp(wideSamp), .monoSamp(monoSamp), .enStart(enStart),
    .baseAddr(baseAddr), .bufBytes(bufBytes), .blkBytes(blkBytes), .irq(irq),
    .bclkRefSel(bclkRefSel), .bclkDivisor(bclkDivisor)
  );

  pcm_dma_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .playEn(playEn), .sampleReady(sampleReady),
    .frameLast(frameLast), .stb(stb), .memReq(memReq), .sampleValid(sampleValid)
  );

  pcm_dma_datapath #(.THR_W(THR_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .enStart(enStart), .wideSamp(wideSamp),
    .monoSamp(monoSamp), .baseAddr(baseAddr), .bufBytes(bufBytes), .blkBytes(blkBytes),
    .memRdata(memRdata), .memAddr(memAddr), .sampleLeft(sampleLeft),
    .sampleRight(sampleRight), .frameLast(frameLast), .halfEvt(halfEvt),
    .fullEvt(fullEvt), .posBytes(posBytes)
  );
endmodule

// File: rtl/pcm_dma_player_chk.sv
module pcm_dma_player_chk #(
  parameter int POS_W = 19
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic             memReq,
  input logic             playEn,
  input logic             sampleValid,
  input logic             sampleReady,
  input logic [15:0]      sampleLeft,
  input logic [15:0]      sampleRight,
  input logic             irq,
  input logic             halfEvt,
  input logic             fullEvt,
  input logic             enStart,
  input logic [POS_W-1:0] posBytes
);
  assert_fetch_only_running_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> playEn);

  assert_valid_only_running_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> playEn);

  assert_one_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({halfEvt, fullEvt}));

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(regWr) || $past(halfEvt) || $past(fullEvt)));

  assert_restart_pos_R10: assert property (@(posedge clk) disable iff (!rstN)
    enStart |=> posBytes == '0);

  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !sampleReady && !regWr) |=> ($stable(sampleLeft) && $stable(sampleRight)));
endmodule

bind pcm_dma_player pcm_dma_player_chk #(.POS_W(POS_W)) uChk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .memReq(memReq), .playEn(playEn),
  .sampleValid(sampleValid), .sampleReady(sampleReady), .sampleLeft(sampleLeft),
  .sampleRight(sampleRight), .irq(irq), .halfEvt(halfEvt), .fullEvt(fullEvt),
  .enStart(enStart), .posBytes(posBytes)
);

// File: tb/sim_pcm_dma_player.sv
`timescale 1ns/1ps
module sim_pcm_dma_player;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic memReq;
  logic [31:0] memAddr;
  logic [31:0] memRdata = '0;
  logic sampleValid;
  logic sampleReady = 1'b0;
  logic [15:0] sampleLeft, sampleRight;
  logic irq, bclkRefSel;
  logic [14:0] bclkDivisor;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] mem [64];

  // reference model state
  logic [31:0] mMode = '0, mDiv = '0, mBase = '0;
  logic [15:0] mThr = '0;
  logic [1:0]  mFlag = '0, mMask = '0;
  int mRd = 0, mPos = 0, mSub = 0;
  logic prevStall = 1'b0;
  logic [15:0] prevL = '0, prevR = '0;

  pcm_dma_player u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memAddr(memAddr), .memRdata(memRdata),
    .sampleValid(sampleValid), .sampleReady(sampleReady), .sampleLeft(sampleLeft),
    .sampleRight(sampleRight), .irq(irq), .bclkRefSel(bclkRefSel), .bclkDivisor(bclkDivisor)
  );

  always #10 clk = ~clk;

  initial begin
    for (int i = 0; i < 64; i++)
      mem[i] = {8'(i * 37 + 5), 8'(i * 91 + 17), 8'(i * 53 + 200), 8'(i * 29 + 66)};
  end

  always @(posedge clk) if (memReq) memRdata <= mem[memAddr[7:2]];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00: return mMode;
      8'h18: return mDiv;
      8'h20: return {24'd0, mFlag, 6'd0};
      8'h24: return {24'd0, mMask, 6'd0};
      8'h38: return 32'(mPos / 4);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string readTag(input logic [7:0] a);
    case (a)
      8'h38: return "R7";
      8'h20: return "R9";
      8'h24: return "R8";
      8'h18: return "R11";
      8'h00: return "R10";
      default: return "R1";
    endcase
  endfunction

  function automatic string fmtTag();
    case ({mMode[0], mMode[14]})
      2'b10: return "R3";
      2'b11: return "R4";
      2'b00: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic int framesPerWord();
    case ({mMode[0], mMode[14]})
      2'b10: return 1;
      2'b11: return 2;
      2'b00: return 2;
      default: return 4;
    endcase
  endfunction

  task automatic modelStep();
    logic [31:0] w, clr;
    logic [15:0] eL, eR;
    logic [7:0] b;
    logic [1:0] evt;
    int bufB, blkB, nr;
    evt = 2'b00;
    chk(irq == |(mFlag & mMask), "R8", "irq", 32'(irq), 32'(|(mFlag & mMask)));
    chk(bclkRefSel == mMode[9], "R11", "bclkRefSel", 32'(bclkRefSel), 32'(mMode[9]));
    chk(32'(bclkDivisor) == (32'(mDiv[15:8]) + 1) * 64, "R11", "bclkDivisor",
        32'(bclkDivisor), (32'(mDiv[15:8]) + 1) * 64);
    chk(regRdata == modelRead(regAddr), readTag(regAddr), "regRdata", regRdata, modelRead(regAddr));
    if (memReq) begin
      chk(mMode[7], "R2", "memReq while stopped", 32'(memReq), 32'(0));
      chk(memAddr == mBase + 32'(mRd), (mRd == 0) ? "R10" : "R2", "memAddr",
          memAddr, mBase + 32'(mRd));
    end
    if (sampleValid) chk(mMode[7], "R2", "sampleValid while stopped", 32'(sampleValid), 32'(0));
    if (sampleValid && prevStall)
      chk(sampleLeft == prevL && sampleRight == prevR, "R12", "stalled sample",
          {sampleLeft, sampleRight}, {prevL, prevR});
    if (sampleValid && sampleReady) begin
      w = mem[((mBase + 32'(mRd)) >> 2) & 32'd63];
      case ({mMode[0], mMode[14]})
        2'b10: begin eL = w[15:0]; eR = w[31:16]; end
        2'b11: begin eL = 16'(w >> (16 * mSub)); eR = eL; end
        2'b00: begin
          eL = 16'(int'(8'(w >> (16 * mSub))) * 256);
          eR = 16'(int'(8'(w >> (16 * mSub + 8))) * 256);
        end
        default: begin b = 8'(w >> (8 * mSub)); eL = 16'(int'(b) * 256); eR = eL; end
      endcase
      chk(sampleLeft == eL && sampleRight == eR, fmtTag(), "frame",
          {sampleLeft, sampleRight}, {eL, eR});
      mSub++;
      if (mSub == framesPerWord()) begin
        mSub = 0;
        bufB = (int'(mThr) + 1) * 4;
        blkB = (int'(mThr) + 1) * 2;
        nr = mRd + 4;
        if (nr >= bufB) begin evt = 2'b10; mRd = 0; mPos = 0; end
        else begin
          if (mRd < blkB && nr >= blkB) begin evt = 2'b01; mPos = blkB; end
          mRd = nr;
        end
      end
    end
    prevStall = sampleValid && !sampleReady && !regWr;
    prevL = sampleLeft;
    prevR = sampleRight;
    clr = (regWr && regAddr == 8'h20) ? regWdata : 32'd0;
    mFlag = (mFlag & ~clr[7:6]) | evt;
    if (regWr) begin
      case (regAddr)
        8'h00: begin
          if (regWdata[7] && !mMode[7]) begin mRd = 0; mPos = 0; mSub = 0; mFlag = 2'b00; end
          mMode = regWdata;
        end
        8'h18: mDiv = regWdata;
        8'h24: mMask = regWdata[7:6];
        8'h28: mBase[15:0] = regWdata[15:0];
        8'h40: mBase[31:16] = regWdata[15:0];
        8'h2C: mThr = regWdata[15:0];
        default: ;
      endcase
    end
  endtask

  initial forever begin
    @(negedge clk);
    #8;
    cycles++;
    if (rstN) modelStep();
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #8;
    chk(regRdata == exp, tag, "register read", regRdata, exp);
  endtask

  task automatic expectIrq(input logic exp, input string tag);
    @(negedge clk);
    #8;
    chk(irq == exp, tag, "irq", 32'(irq), 32'(exp));
  endtask

  task automatic runFrames(input int n, input bit stall);
    int got = 0;
    int guard = 0;
    while (got < n && guard < 5000) begin
      @(negedge clk);
      sampleReady = stall ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #8;
      if (sampleValid && sampleReady) got++;
      guard++;
    end
    @(negedge clk);
    sampleReady = 1'b0;
    chk(got == n, "R2", "frames delivered", 32'(got), 32'(n));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    peek(8'h00, 32'h0, "R1");
    peek(8'h20, 32'h0, "R1");
    peek(8'h24, 32'h0, "R1");
    peek(8'h38, 32'h0, "R1");
    chk(!irq && !memReq, "R1", "irq/memReq after reset", {30'd0, irq, memReq}, 32'd0);

    // configure: base 0x0003_0040, 32-byte buffer, 16-byte halves
    regWrite(8'h28, 32'h0000_0040);
    regWrite(8'h40, 32'h0000_0003);
    regWrite(8'h2C, 32'd7);
    repeat (6) @(negedge clk);
    chk(!memReq, "R2", "no fetch while stopped", 32'(memReq), 32'd0);

    // R3 stereo 16-bit
    regWrite(8'h00, 32'h0000_0081);
    runFrames(4, 1'b0);
    peek(8'h38, 32'd4, "R7");
    peek(8'h20, 32'h40, "R7");
    expectIrq(1'b0, "R8");
    regWrite(8'h24, 32'hC0);
    expectIrq(1'b1, "R8");
    runFrames(4, 1'b1);
    peek(8'h20, 32'hC0, "R7");
    peek(8'h38, 32'd0, "R7");
    regWrite(8'h20, 32'h40);
    peek(8'h20, 32'h80, "R9");
    regWrite(8'h20, 32'h80);
    peek(8'h20, 32'h00, "R9");
    expectIrq(1'b0, "R9");
    runFrames(8, 1'b1);

    // R10 restart mid-buffer, R4 mono 16-bit
    runFrames(2, 1'b0);
    regWrite(8'h00, 32'h0);
    repeat (8) @(negedge clk);
    regWrite(8'h00, 32'h0000_4081);
    peek(8'h38, 32'd0, "R10");
    peek(8'h20, 32'h0, "R10");
    runFrames(16, 1'b1);

    // R5 8-bit stereo
    regWrite(8'h00, 32'h0);
    regWrite(8'h00, 32'h0000_0080);
    runFrames(16, 1'b0);

    // R6 8-bit mono
    regWrite(8'h00, 32'h0);
    regWrite(8'h00, 32'h0000_4080);
    runFrames(32, 1'b1);

    // R7 one-word buffer: wrap only
    regWrite(8'h00, 32'h0);
    regWrite(8'h2C, 32'd0);
    regWrite(8'h00, 32'h0000_0081);
    runFrames(1, 1'b0);
    peek(8'h20, 32'h80, "R7");
    peek(8'h38, 32'd0, "R7");
    runFrames(3, 1'b1);

    // R11 bit-clock selection
    regWrite(8'h00, 32'h0);
    regWrite(8'h18, 32'h0000_0500);
    regWrite(8'h00, 32'h0000_0200);
    @(negedge clk); #8;
    chk(bclkRefSel == 1'b1 && bclkDivisor == 15'd384, "R11", "bclk fast /6",
        {16'(bclkRefSel), 16'(bclkDivisor)}, {16'd1, 16'd384});
    regWrite(8'h18, 32'h0000_FF00);
    regWrite(8'h00, 32'h0);
    @(negedge clk); #8;
    chk(bclkRefSel == 1'b0 && bclkDivisor == 15'd16384, "R11", "bclk slow /256",
        {16'(bclkRefSel), 16'(bclkDivisor)}, {16'd0, 16'd16384});
    repeat (5) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule